// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block sits between a processor-side word port and a slower memory-side port. Each word address selects one set through its middle bits. Inside that set, all ways compare their stored tags at the same time, and a way only counts if its valid bit is set. A hit is accepted in the same cycle the request is presented, and the response follows one cycle later. On a miss the requester is stalled while the controller picks a victim way. If that way holds modified data, the controller writes it back. It then loads the whole line one word per memory beat. After that the held request completes as an ordinary hit.

Replacement uses a small saturating usage counter per line. A parameter chooses the store policy. In write-back mode a store marks the line dirty and memory is only written on eviction. In write-through mode every store also performs a single memory write beat, and no line is ever dirty.

Top module: `sa_cache`

## Requirements
- R1: After reset no line is valid and every usage counter is zero; no memory request and no response are issued until a request arrives, and the first access to any set misses.
- R2: The word address splits as offset = low log2(LINE_WORDS) bits, set = next log2(SETS) bits, tag = remaining upper bits; a hit (valid way in the set with equal tag) raises `cpu_req_ready` in the request cycle, gives `cpu_rsp_valid` exactly one cycle after acceptance and causes no memory traffic.
- R3: A line fill reads the words {tag, set, 0} up to {tag, set, LINE_WORDS-1} in ascending order, one word per `mem_req`/`mem_ack` beat, holding the request and address stable until acknowledged.
- R4: On a miss `cpu_req_ready` stays low until any eviction and the fill have finished; the filled way becomes valid only after its last beat, after which the held access completes as a hit.
- R5: On a miss the lowest-numbered invalid way of the set is filled first.
- R6: On each accepted access the used way's counter becomes zero and the counters of the other valid ways in that set increment, saturating at 2^CNT_W-1; when the set is full the victim is the way with the highest count, ties going to the lowest way number.
- R7: In write-back mode a store hit updates only the cache, marks the line dirty and produces no memory write.
- R8: In write-back mode a dirty victim is written back (all LINE_WORDS words, ascending offsets, with its current contents) before the new line is read.
- R9: A clean victim is replaced without any memory write.
- R10: In write-through mode each store performs exactly one memory write of the store data to the store address, the store is accepted only after that beat is acknowledged, store misses allocate the line first, and no eviction write ever occurs.
- R11: A load returns the most recently stored value of its address; a store's response carries the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present (held until accepted) |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| cpu_rsp_rdata | output | DATA_W | Load data or echoed store data |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | ADDR_W | Memory word address of the beat |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory beat completed (one cycle pulse) |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
A directed sequence fills one set in order and then revisits chosen tags. Because the hit/miss results depend on it, this sequence separates free-way-first placement from counter-based victim choice, and it also separates the lowest-way tie rule from any other order. A long mixed sweep of loads and stores then runs over six tags, four sets and all offsets against both store policies. The bench keeps a reference model of tags, dirty bits and counters, and from it predicts stall versus no stall, the number of memory reads and writes, the fill beat order, the written-back contents and the returned data. Here the write-back and write-through instances differ only in their write traffic and in when a store is accepted.

// File: rtl/sa_cache_pkg.sv
// Shared types for the set-associative cache controller.
package sa_cache_pkg;
    // Controller states: idle/lookup, write back victim, load line, write-through store beat.
    typedef enum logic [1:0] {ST_IDLE, ST_EVICT, ST_FILL, ST_WTW} cache_state_e;
endpackage

// File: rtl/sa_cache_match.sv
// Parallel tag comparison over the ways of one set.
// Assumes at most one valid way carries a given tag (the controller guarantees it);
// if several did, the lowest way would be reported.
module sa_cache_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAYS-1:0] match;

    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    assign hit_o = |match;

    // Encode the matching way, lowest index wins.
    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sa_cache_repl.sv
// Per-line saturating usage counters and victim selection for one set at a time.
// Assumes touch and query refer to the same set (the set of the current request).
module sa_cache_repl #(
    parameter int WAYS  = 4,
    parameter int SETS  = 4,
    parameter int CNT_W = 2,
    parameter int WAY_W = $clog2(WAYS),
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] touch_way_i,
    output logic [WAY_W-1:0] victim_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WAYS-1:0][CNT_W-1:0] cnt_q [SETS];
    logic [WAYS-1:0][CNT_W-1:0] cur;
    logic [CNT_W-1:0]           best;
    logic                       free_found;

    assign cur = cnt_q[set_i];

    // Counter update: used way to zero, other valid ways saturate upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
        end else if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way_i)           cnt_q[set_i][w] <= '0;
                else if (valid_i[w] && cur[w] != CNT_MAX) cnt_q[set_i][w] <= cur[w] + 1'b1;
            end
        end
    end

    // Victim: lowest invalid way, else highest count with lowest-way tie break.
    always_comb begin
        victim_o   = '0;
        best       = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_i[w] && !free_found) begin
                free_found = 1'b1;
                victim_o   = WAY_W'(w);
            end
        end
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (w == 0 || cur[w] > best) begin
                    best     = cur[w];
                    victim_o = WAY_W'(w);
                end
            end
        end
    end

    // R5: with a free way present the chosen victim is never a valid way.
    a_r5_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i != '1) |-> !valid_i[victim_o]);

    // R6: a touched line's counter reads zero afterwards.
    a_r6_touch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> (cnt_q[$past(set_i)][$past(touch_way_i)] == '0));
endmodule

// File: rtl/sa_cache.sv
// N-way set-associative cache controller, word port to line-beat memory port.
// Assumes the requester holds valid, address, data and we stable until ready,
// LINE_WORDS and SETS are powers of two, WAYS >= 2, and memory acks each beat once.
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int LINE_WORDS = 4,
    parameter int CNT_W      = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            val_q   [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [DATA_W-1:0]          data_q  [SETS][WAYS][LINE_WORDS];

    cache_state_e     state_q;
    logic [TAG_W-1:0] m_tag_q, e_tag_q;
    logic [IDX_W-1:0] m_set_q;
    logic [WAY_W-1:0] m_way_q;
    logic [OFF_W-1:0] beat_q;
    logic             wt_done_q;

    logic [TAG_W-1:0] in_tag;
    logic [IDX_W-1:0] in_set;
    logic [OFF_W-1:0] in_off;
    logic             hit, accept, wt_need, victim_dirty, last_beat;
    logic [WAY_W-1:0] hit_way, victim;

    assign in_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign in_set = cpu_req_addr[OFF_W +: IDX_W];
    assign in_off = cpu_req_addr[OFF_W-1:0];

    sa_cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags_i (tag_q[in_set]),
        .valid_i(val_q[in_set]),
        .tag_i  (in_tag),
        .hit_o  (hit),
        .way_o  (hit_way)
    );

    sa_cache_repl #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (in_set),
        .valid_i    (val_q[in_set]),
        .touch_i    (accept),
        .touch_way_i(hit_way),
        .victim_o   (victim)
    );

    assign wt_need       = !WRITE_BACK && cpu_req_we;
    assign cpu_req_ready = (state_q == ST_IDLE) && hit && (!wt_need || wt_done_q);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign victim_dirty  = WRITE_BACK && val_q[in_set][victim] && dirty_q[in_set][victim];
    assign last_beat     = (beat_q == LAST_BEAT);

    // Controller sequencing plus tag, valid and dirty state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            m_tag_q       <= '0;
            e_tag_q       <= '0;
            m_set_q       <= '0;
            m_way_q       <= '0;
            beat_q        <= '0;
            wt_done_q     <= 1'b0;
            cpu_rsp_valid <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            cpu_rsp_valid <= accept;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        wt_done_q <= 1'b0;
                        if (cpu_req_we && WRITE_BACK) dirty_q[in_set][hit_way] <= 1'b1;
                    end else if (cpu_req_valid && !hit) begin
                        m_tag_q               <= in_tag;
                        m_set_q               <= in_set;
                        m_way_q               <= victim;
                        e_tag_q               <= tag_q[in_set][victim];
                        val_q[in_set][victim] <= 1'b0;
                        beat_q                <= '0;
                        state_q               <= victim_dirty ? ST_EVICT : ST_FILL;
                    end else if (cpu_req_valid && wt_need && !wt_done_q) begin
                        state_q <= ST_WTW;
                    end
                end
                ST_EVICT: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        val_q[m_set_q][m_way_q]   <= 1'b1;
                        dirty_q[m_set_q][m_way_q] <= 1'b0;
                        tag_q[m_set_q][m_way_q]   <= m_tag_q;
                        state_q                   <= ST_IDLE;
                    end
                end
                default: if (mem_ack) begin
                    wt_done_q <= 1'b1;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    // Line data: processor stores and fill beats; response data capture.
    always_ff @(posedge clk) begin
        if (accept && cpu_req_we) data_q[in_set][hit_way][in_off] <= cpu_req_wdata;
        if (state_q == ST_FILL && mem_ack) data_q[m_set_q][m_way_q][beat_q] <= mem_rdata;
        if (accept) cpu_rsp_rdata <= cpu_req_we ? cpu_req_wdata : data_q[in_set][hit_way][in_off];
    end

    // Memory-side beat generation from the current state.
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_EVICT) || (state_q == ST_WTW);
        mem_addr  = {m_tag_q, m_set_q, beat_q};
        mem_wdata = '0;
        case (state_q)
            ST_EVICT: begin
                mem_addr  = {e_tag_q, m_set_q, beat_q};
                mem_wdata = data_q[m_set_q][m_way_q][beat_q];
            end
            ST_WTW: begin
                mem_addr  = cpu_req_addr;
                mem_wdata = cpu_req_wdata;
            end
            default: ;
        endcase
    end

    // R2: a response follows each acceptance and only an acceptance.
    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cpu_rsp_valid);
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !cpu_rsp_valid);

    // R3: an unacknowledged beat keeps its request and address.
    a_r3_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: the way being filled is never visible as valid before the fill ends.
    a_r4_fill_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !val_q[m_set_q][m_way_q]);

    // R10: in write-through mode every memory write targets the store address.
    if (!WRITE_BACK) begin : g_wt_chk
        a_r10_wt_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_we) |-> (cpu_req_we && mem_addr == cpu_req_addr
                                      && mem_wdata == cpu_req_wdata));
    end
endmodule

// File: tb/sa_cache_tb_top.sv
`timescale 1ns/1ps

// Memory responder for the bench: acks each beat one cycle after it is seen.
module cache_mem_model #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    int n_rd, n_wr, n_bad;
    int rd_log [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
            n_rd  <= 0;
            n_wr  <= 0;
            n_bad <= 0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(32'h5A00_0000 ^ (i * 32'h0001_0103));
            for (int i = 0; i < 4; i++) rd_log[i] <= -1;
        end else begin
            ack <= req && !ack;
            if (req && !ack) begin
                if (int'(addr) >= DEPTH) n_bad <= n_bad + 1;
                else if (we) begin
                    mem[int'(addr)] <= wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    rdata <= mem[int'(addr)];
                    n_rd  <= n_rd + 1;
                    for (int i = 0; i < 3; i++) rd_log[i] <= rd_log[i+1];
                    rd_log[3] <= int'(addr);
                end
            end
        end
    end
endmodule

module sa_cache_tb_top;
    localparam int AW = 16, DW = 32, NWAY = 4, NSET = 4, NWORD = 4, CMAX = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]    rv = '0, rwe = '0;
    logic [AW-1:0] ra [2];
    logic [DW-1:0] rwd [2];
    logic [1:0]    rdy, rspv, mreq, mwe, mack;
    logic [DW-1:0] rrd [2];
    logic [AW-1:0] maddr [2];
    logic [DW-1:0] mwd [2], mrd [2];

    sa_cache #(.WRITE_BACK(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(rv[0]), .cpu_req_ready(rdy[0]),
        .cpu_req_we(rwe[0]), .cpu_req_addr(ra[0]), .cpu_req_wdata(rwd[0]),
        .cpu_rsp_valid(rspv[0]), .cpu_rsp_rdata(rrd[0]), .mem_req(mreq[0]), .mem_we(mwe[0]),
        .mem_addr(maddr[0]), .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]));
    sa_cache #(.WRITE_BACK(1'b0)) dut_wt_i (
        .clk(clk), .rst_n(rst_n), .cpu_req_valid(rv[1]), .cpu_req_ready(rdy[1]),
        .cpu_req_we(rwe[1]), .cpu_req_addr(ra[1]), .cpu_req_wdata(rwd[1]),
        .cpu_rsp_valid(rspv[1]), .cpu_rsp_rdata(rrd[1]), .mem_req(mreq[1]), .mem_we(mwe[1]),
        .mem_addr(maddr[1]), .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]));
    cache_mem_model mem0 (.clk(clk), .rst_n(rst_n), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]),
        .wdata(mwd[0]), .ack(mack[0]), .rdata(mrd[0]));
    cache_mem_model mem1 (.clk(clk), .rst_n(rst_n), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]),
        .wdata(mwd[1]), .ack(mack[1]), .rdata(mrd[1]));

    int tests = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    // Reference model state: per instance, set, way.
    bit          m_val [2][NSET][NWAY];
    bit          m_dirty [2][NSET][NWAY];
    int          m_tag [2][NSET][NWAY];
    int          m_cnt [2][NSET][NWAY];
    logic [DW-1:0] shadow [2][256];

    function automatic int get_rd(int k);  return k == 0 ? mem0.n_rd : mem1.n_rd; endfunction
    function automatic int get_wr(int k);  return k == 0 ? mem0.n_wr : mem1.n_wr; endfunction
    function automatic logic [DW-1:0] get_mem(int k, int a);
        return k == 0 ? mem0.mem[a] : mem1.mem[a];
    endfunction
    function automatic int get_log(int k, int i);
        return k == 0 ? mem0.rd_log[i] : mem1.rd_log[i];
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One processor access with full prediction and checking.
    task automatic access(int k, bit we, int tag, int set, int off, logic [DW-1:0] wd);
        int addr, way, r0, w0, waitc, base;
        bit hit, evict;
        logic [DW-1:0] exp_data, old_mem;
        logic [DW-1:0] line_old [NWORD];
        addr = tag * 16 + set * 4 + off;
        base = addr - off;
        hit = 0; way = 0;
        for (int w = 0; w < NWAY; w++)
            if (m_val[k][set][w] && m_tag[k][set][w] == tag) begin hit = 1; way = w; end
        evict = 0;
        if (!hit) begin
            bit free;
            int best;
            free = 0; best = -1;
            for (int w = 0; w < NWAY; w++)
                if (!m_val[k][set][w] && !free) begin free = 1; way = w; end
            if (!free)
                for (int w = 0; w < NWAY; w++)
                    if (m_cnt[k][set][w] > best) begin best = m_cnt[k][set][w]; way = w; end
            evict = (k == 0) && m_val[k][set][way] && m_dirty[k][set][way];
            for (int i = 0; i < NWORD; i++) line_old[i] = shadow[k][m_tag[k][set][way]*16 + set*4 + i];
        end
        exp_data = we ? wd : shadow[k][addr];
        old_mem  = get_mem(k, addr);
        r0 = get_rd(k); w0 = get_wr(k);

        @(negedge clk);
        rv[k] = 1'b1; rwe[k] = we; ra[k] = AW'(addr); rwd[k] = wd;
        waitc = 0;
        #1;
        while (!rdy[k] && waitc < 200) begin
            @(negedge clk); #1; waitc++;
        end
        @(negedge clk);
        rv[k] = 1'b0;
        chk(rspv[k] == 1'b1, "R2", "response one cycle after accept", rspv[k], 1);
        chk(rrd[k] == exp_data, "R11", "response data", rrd[k], exp_data);
        if (hit && !(k == 1 && we))
            chk(waitc == 0, "R2", "hit accepted without stall", waitc, 0);
        else
            chk(waitc > 0, hit ? "R10" : "R4", "stall before acceptance", waitc, 1);
        if (!hit)
            chk(hit == 0 && waitc > 0, "R5 R6", $sformatf("predicted miss k%0d t%0d s%0d", k, tag, set), waitc, 1);
        chk(get_rd(k) - r0 == (hit ? 0 : NWORD), "R4", "fill read beats", get_rd(k) - r0, hit ? 0 : NWORD);
        if (!hit)
            for (int i = 0; i < NWORD; i++)
                chk(get_log(k, i) == base + i, "R3", "fill beat order", get_log(k, i), base + i);
        if (k == 1)
            chk(get_wr(k) - w0 == (we ? 1 : 0), "R10", "write-through write beats", get_wr(k) - w0, we ? 1 : 0);
        else if (evict)
            chk(get_wr(k) - w0 == NWORD, "R8", "dirty eviction beats", get_wr(k) - w0, NWORD);
        else
            chk(get_wr(k) - w0 == 0, hit ? "R7" : "R9", "no memory write", get_wr(k) - w0, 0);
        if (evict)
            for (int i = 0; i < NWORD; i++) begin
                int ea;
                ea = m_tag[k][set][way] * 16 + set * 4 + i;
                chk(get_mem(k, ea) == line_old[i], "R8", "written-back word", get_mem(k, ea), line_old[i]);
            end
        if (k == 0 && we && hit)
            chk(get_mem(k, addr) == old_mem, "R7", "store hit leaves memory", get_mem(k, addr), old_mem);
        if (k == 1 && we)
            chk(get_mem(k, addr) == wd, "R10", "write-through memory word", get_mem(k, addr), wd);

        // Update the reference model.
        if (!hit) begin
            m_val[k][set][way] = 1; m_tag[k][set][way] = tag; m_dirty[k][set][way] = 0;
        end
        for (int w = 0; w < NWAY; w++)
            if (w == way) m_cnt[k][set][w] = 0;
            else if (m_val[k][set][w] && m_cnt[k][set][w] < CMAX) m_cnt[k][set][w]++;
        if (we) begin
            shadow[k][addr] = wd;
            if (k == 0) m_dirty[k][set][way] = 1;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        ra[0] = '0; ra[1] = '0; rwd[0] = '0; rwd[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(mreq[k] == 0, "R1", "no memory request after reset", mreq[k], 0);
            chk(rspv[k] == 0, "R1", "no response after reset", rspv[k], 0);
            for (int a = 0; a < 256; a++) shadow[k][a] = get_mem(k, a);
            for (int s = 0; s < NSET; s++)
                for (int w = 0; w < NWAY; w++) begin
                    m_val[k][s][w] = 0; m_dirty[k][s][w] = 0; m_tag[k][s][w] = 0; m_cnt[k][s][w] = 0;
                end
        end
        // R1: first access after reset misses.
        rv[0] = 1'b1; ra[0] = 16'h0005; #1;
        chk(rdy[0] == 0, "R1", "first access not ready", rdy[0], 0);
        rv[0] = 1'b0;

        // Directed placement and replacement order (R5, R6), both policies.
        for (int k = 0; k < 2; k++) begin
            access(k, 0, 1, 0, 0, '0);
            access(k, 1, 2, 0, 1, 32'hCAFE_0002);
            access(k, 0, 3, 0, 2, '0);
            access(k, 1, 4, 0, 3, 32'hCAFE_0004);
            access(k, 0, 1, 0, 1, '0);
            access(k, 0, 5, 0, 0, '0);
            access(k, 0, 1, 0, 2, '0);
            access(k, 0, 3, 0, 0, '0);
            access(k, 0, 4, 0, 1, '0);
            access(k, 0, 2, 0, 3, '0);
            access(k, 0, 4, 0, 2, '0);
            access(k, 0, 6, 0, 0, '0);
            access(k, 0, 3, 0, 1, '0);
            access(k, 0, 1, 0, 1, '0);
        end

        // Mixed sweep over tags, sets, offsets and store/load.
        for (int k = 0; k < 2; k++) begin
            seed = 32'h1234 + k;
            for (int n = 0; n < 300; n++) begin
                seed = seed * 1103515245 + 12345;
                access(k, ((seed >>> 20) & 7) < 3, ((seed >>> 8) & 32'h7fff) % 6,
                       (seed >>> 12) & 3, (seed >>> 16) & 3, DW'(seed ^ (n << 4)));
            end
        end

        // R10: write-through memory equals the program-visible contents.
        for (int a = 0; a < 128; a++)
            chk(get_mem(1, a) == shadow[1][a], "R10", $sformatf("memory word %0d", a), get_mem(1, a), shadow[1][a]);
        chk(mem0.n_bad == 0 && mem1.n_bad == 0, "R3", "memory addresses in range", mem0.n_bad + mem1.n_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule